// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Condition Flags

This block is the arithmetic core of an 8-bit accumulator machine. Each cycle it takes an operation code, two operands and the machine's current condition flags. One clock edge later it presents the arithmetic result and the updated flags. It covers seven operations: add, add with carry-in, subtract, subtract with borrow-in, negate, increment and decrement. An eighth code passes the first operand through.

Each flag follows its usual arithmetic meaning. The flags are half-carry out of the low nibble, negative, zero, two's-complement overflow and carry/borrow. Not every operation is allowed to change every flag. A fixed per-operation mask decides which flags take a freshly computed value and which keep their incoming value. This lets increment and decrement serve as loop counters without disturbing a pending carry.

The surrounding datapath feeds the registered flags back into the flag input on the next operation. All operations share a single adder. Operand steering turns subtraction, negation and the unary operations into additions with chosen inputs and carry-in.

Top module: `alu_cc`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result_o` and `flags_o` become all zeros.
- R2: Outputs are registered. After each rising edge with `rst` low, they reflect the inputs sampled at that edge and stay steady until the next edge.
- R3: For every operation code except 7, flag Z (`flags_o[2]`) is 1 exactly when the result is zero.
- R4: For every operation code except 7, flag N (`flags_o[3]`) equals bit 7 of the result.
- R5: Codes 0 (add) and 1 (add with carry-in) produce A+B (+C for code 1) modulo 256. They update all five flags:
  - C (`flags_o[0]`) is the carry out of bit 7.
  - H (`flags_o[4]`) is the carry out of bit 3 into bit 4.
  - V (`flags_o[1]`) is set when both operands share a sign bit and the result's sign bit differs.
- R6: Codes 5 (increment A) and 6 (decrement A) keep C and H at their incoming values. V is set only for increment of 0x7F and decrement of 0x80.
- R7: Codes 2 (subtract) and 3 (subtract with borrow-in) produce A−B (−C for code 3) modulo 256. They keep H unchanged. C is set when unsigned A is less than B plus the borrow-in. V is set when the operands' sign bits differ and the result's sign bit differs from A's.
- R8: For codes 1 and 3 the incoming C flag (`flags_i[0]`) takes part in the arithmetic. For codes 0 and 2 it does not.
- R9: Code 4 produces 0−A modulo 256 and ignores B. It sets C when the result is nonzero, sets V only when A is 0x80, and keeps H unchanged.
- R10: Code 7 passes A to the result and returns all five flags exactly as given on `flags_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Operation code (0 add, 1 add+C, 2 sub, 3 sub−C, 4 negate, 5 inc, 6 dec, 7 pass) |
| a_i | input | 8 | Operand A (accumulator side) |
| b_i | input | 8 | Operand B (memory side) |
| flags_i | input | 5 | Current flags {H,N,Z,V,C}, bit 4 down to bit 0 |
| result_o | output | 8 | Registered result |
| flags_o | output | 5 | Registered new flags {H,N,Z,V,C} |

## Verification
Some properties are checked by assertions on every cycle:
- Z and N track the registered result.
- C and H are left untouched by the operations whose mask excludes them.
- Negate raises V only for the most negative operand.
- The pass code returns A.

Whether the computed carries, borrows, half-carries and overflows are numerically correct can only be shown by the bench. It sweeps every value of A against a dense spread of B values for all four binary operations, with both carry-in values. It also runs every A value through the unary operations.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBC  = 3'd3,
    OP_NEG  = 3'd4,
    OP_INC  = 3'd5,
    OP_DEC  = 3'd6,
    OP_PASS = 3'd7
  } alu_op_e;

  localparam int CC_W = 5;

  // flag vector order: h n z v c (bit 4 down to bit 0)
  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;

  // which flags an operation is allowed to rewrite
  function automatic logic [CC_W-1:0] flag_mask(alu_op_e op);
    logic [CC_W-1:0] m;
    case (op)
      OP_ADD, OP_ADC:         m = 5'b11111;
      OP_SUB, OP_SBC, OP_NEG: m = 5'b01111;
      OP_INC, OP_DEC:         m = 5'b01110;
      default:                m = 5'b00000;
    endcase
    return m;
  endfunction

  // operations whose carry-out must be inverted into a borrow
  function automatic logic is_borrow_op(alu_op_e op);
    return (op == OP_SUB) || (op == OP_SBC) || (op == OP_NEG) || (op == OP_DEC);
  endfunction

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
  import alu_cc_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           c_in,
  output logic [W-1:0]   x,
  output logic [W-1:0]   y,
  output logic           cin,
  output logic           borrow_mode
);

  always_comb begin
    x   = a;
    y   = '0;
    cin = 1'b0;
    case (op)
      OP_ADD: begin y = b;  cin = 1'b0;  end
      OP_ADC: begin y = b;  cin = c_in;  end
      OP_SUB: begin y = ~b; cin = 1'b1;  end
      OP_SBC: begin y = ~b; cin = ~c_in; end
      OP_NEG: begin x = '0; y = ~a; cin = 1'b1; end
      OP_INC: begin y = '0; cin = 1'b1;  end
      OP_DEC: begin y = '1; cin = 1'b0;  end
      default: begin y = '0; cin = 1'b0; end
    endcase
  end

  assign borrow_mode = is_borrow_op(op);

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_top,
  output logic         c_half,
  output logic         ovf
);

  localparam int HALF = W / 2;
  localparam int UPW  = W - HALF;

  logic [HALF:0] lo;
  logic [UPW:0]  hi;

  // split at the nibble boundary so the half carry falls out directly
  assign lo = {1'b0, x[HALF-1:0]} + {1'b0, y[HALF-1:0]} + {{HALF{1'b0}}, cin};
  assign hi = {1'b0, x[W-1:HALF]} + {1'b0, y[W-1:HALF]} + {{UPW{1'b0}}, lo[HALF]};

  assign sum    = {hi[UPW-1:0], lo[HALF-1:0]};
  assign c_half = lo[HALF];
  assign c_top  = hi[UPW];
  assign ovf    = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);

endmodule

// File: rtl/alu_flag_merge.sv
module alu_flag_merge
  import alu_cc_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e          op,
  input  logic [W-1:0]     sum,
  input  logic             c_top,
  input  logic             c_half,
  input  logic             ovf,
  input  logic             borrow_mode,
  input  logic [CC_W-1:0]  flags_in,
  output logic [CC_W-1:0]  flags_out
);

  cc_t             fresh;
  logic [CC_W-1:0] mask;
  logic [CC_W-1:0] fresh_v;

  always_comb begin
    fresh.h = c_half;
    fresh.n = sum[W-1];
    fresh.z = ~|sum;
    fresh.v = ovf;
    fresh.c = borrow_mode ? ~c_top : c_top;
  end

  assign mask    = flag_mask(op);
  assign fresh_v = fresh;

  for (genvar i = 0; i < CC_W; i++) begin : g_bit
    assign flags_out[i] = mask[i] ? fresh_v[i] : flags_in[i];
  end

endmodule

// File: rtl/alu_cc.sv
module alu_cc
  import alu_cc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [CC_W-1:0]  flags_i,
  output logic [W-1:0]     result_o,
  output logic [CC_W-1:0]  flags_o
);

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  alu_op_e         op;
  logic [W-1:0]    x, y, sum;
  logic            cin, borrow_mode, c_top, c_half, ovf;
  logic [CC_W-1:0] flags_next;
  logic [W-1:0]    result_q;
  logic [CC_W-1:0] flags_q;
  logic            loaded_q;

  assign op = alu_op_e'(op_i);

  alu_operand_prep #(.W(W)) u_prep (
    .op(op), .a(a_i), .b(b_i), .c_in(flags_i[0]),
    .x(x), .y(y), .cin(cin), .borrow_mode(borrow_mode)
  );

  alu_adder #(.W(W)) u_add (
    .x(x), .y(y), .cin(cin),
    .sum(sum), .c_top(c_top), .c_half(c_half), .ovf(ovf)
  );

  alu_flag_merge #(.W(W)) u_merge (
    .op(op), .sum(sum), .c_top(c_top), .c_half(c_half), .ovf(ovf),
    .borrow_mode(borrow_mode), .flags_in(flags_i), .flags_out(flags_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      flags_q  <= '0;
      loaded_q <= 1'b0;
    end else begin
      result_q <= sum;
      flags_q  <= flags_next;
      loaded_q <= 1'b1;
    end
  end

  assign result_o = result_q;
  assign flags_o  = flags_q;

  AST_Z_TRACKS: assert property (@(posedge clk) disable iff (rst)
    loaded_q && ($past(op_i) != 3'd7) |-> (flags_o[2] == (result_o == '0))); // R3
  AST_N_TRACKS: assert property (@(posedge clk) disable iff (rst)
    loaded_q && ($past(op_i) != 3'd7) |-> (flags_o[3] == result_o[W-1])); // R4
  AST_C_KEPT: assert property (@(posedge clk) disable iff (rst)
    loaded_q && ($past(op_i) >= 3'd5) |-> (flags_o[0] == $past(flags_i[0]))); // R6
  AST_H_KEPT: assert property (@(posedge clk) disable iff (rst)
    loaded_q && ($past(op_i) >= 3'd2) |-> (flags_o[4] == $past(flags_i[4]))); // R7
  AST_NEG_OVF: assert property (@(posedge clk) disable iff (rst)
    loaded_q && ($past(op_i) == 3'd4) |-> (flags_o[1] == ($past(a_i) == MOST_NEG))); // R9
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
    loaded_q && ($past(op_i) == 3'd7) |-> (result_o == $past(a_i)) && (flags_o == $past(flags_i))); // R10

endmodule

// File: tb/test_alu_cc.sv
module test_alu_cc;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op_i = '0;
  logic [7:0] a_i = '0, b_i = '0;
  logic [4:0] flags_i = '0;
  logic [7:0] result_o;
  logic [4:0] flags_o;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  alu_cc i_alu_cc (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .flags_i(flags_i), .result_o(result_o), .flags_o(flags_o)
  );

  // returns {result, h, n, z, v, c}
  function automatic logic [12:0] model(int op, logic [7:0] a, logic [7:0] b, logic [4:0] f);
    logic [7:0] r;
    logic h, n, z, v, c;
    int s, k;
    {h, n, z, v, c} = f;
    r = a;
    k = 0;
    case (op)
      0, 1: begin
        k = (op == 1) ? int'(f[0]) : 0;
        s = int'(a) + int'(b) + k;
        r = s[7:0];
        c = s > 255;
        h = (int'(a % 16) + int'(b % 16) + k) > 15;
        v = (a[7] == b[7]) && (r[7] != a[7]);
      end
      2, 3: begin
        k = (op == 3) ? int'(f[0]) : 0;
        s = int'(a) - int'(b) - k;
        r = s[7:0];
        c = int'(a) < int'(b) + k;
        v = (a[7] != b[7]) && (r[7] != a[7]);
      end
      4: begin
        r = 8'(0 - int'(a));
        c = r != 8'h00;
        v = a == 8'h80;
      end
      5: begin r = a + 8'd1; v = a == 8'h7F; end
      6: begin r = a - 8'd1; v = a == 8'h80; end
      default: r = a;
    endcase
    if (op != 7) begin
      n = r[7];
      z = r == 8'h00;
    end
    return {r, h, n, z, v, c};
  endfunction

  function automatic string tag_of(int op, logic cf);
    case (op)
      0: return "R5";
      1: return cf ? "R8" : "R5";
      2: return "R7";
      3: return cf ? "R8" : "R7";
      4: return "R9";
      5, 6: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, logic [12:0] act, logic [12:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got res=%h fl=%b, want res=%h fl=%b", tag,
               act[12:5], act[4:0], exp[12:5], exp[4:0]);
    end
  endtask

  task automatic apply(int op, logic [7:0] a, logic [7:0] b, logic [4:0] f);
    @(negedge clk);
    op_i = 3'(op); a_i = a; b_i = b; flags_i = f;
    @(posedge clk);
    #1;
    chk(tag_of(op, f[0]), {result_o, flags_o}, model(op, a, b, f));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got running, want finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset clears outputs
    op_i = 3'd0; a_i = 8'hFF; b_i = 8'hFF; flags_i = 5'h1F;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", {result_o, flags_o}, 13'h0);
    @(negedge clk);
    rst = 1'b0;

    // R3: zero result sets Z (0x80 + 0x80 wraps to 0)
    apply(0, 8'h80, 8'h80, 5'h00);
    total++;
    if (flags_o[2] !== 1'b1) begin bad++; $display("FAIL R3: got z=%b, want z=1", flags_o[2]); end

    // R4: negative result sets N (0x10 - 0x20)
    apply(2, 8'h10, 8'h20, 5'h00);
    total++;
    if (flags_o[3] !== 1'b1) begin bad++; $display("FAIL R4: got n=%b, want n=1", flags_o[3]); end

    // R2: changing inputs between edges leaves the outputs alone
    @(negedge clk);
    op_i = 3'd0; a_i = 8'h01; b_i = 8'h01; flags_i = 5'h00;
    #1;
    chk("R2", {result_o, flags_o}, model(2, 8'h10, 8'h20, 5'h00));

    // R8: incoming C must not affect plain add / subtract
    apply(0, 8'h05, 8'h03, 5'h01);
    apply(2, 8'h05, 8'h03, 5'h01);

    // binary operations: all A, dense B, both carry-in values
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 5) begin
        for (int op = 0; op < 4; op++) begin
          apply(op, 8'(a), 8'(b), {3'(a + b), 1'b0, 1'(b + op)});
        end
      end
      apply(1, 8'(a), 8'hFF, 5'h01);
      apply(3, 8'(a), 8'hFF, 5'h01);
    end

    // unary and pass operations: all A, flags all-clear and all-set
    for (int a = 0; a < 256; a++) begin
      for (int op = 4; op < 8; op++) begin
        apply(op, 8'(a), 8'(~a), 5'h00);
        apply(op, 8'(a), 8'(a * 7), 5'h1F);
      end
    end

    // R6 boundaries
    apply(5, 8'h7F, 8'h00, 5'h11);
    apply(6, 8'h80, 8'h00, 5'h11);
    // R9 boundaries
    apply(4, 8'h80, 8'h12, 5'h10);
    apply(4, 8'h00, 8'h34, 5'h11);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule